// File: doc/BRIEF.md
# Trace Register Access Chain

This block is a 40-bit test-port data register that lets an external debugger read and write a 128-entry, 32-bit register file belonging to a trace unit. It sits beside a standard TAP controller and consumes its Capture-DR, Shift-DR and Update-DR strobes, its serial data pins and its current instruction code. On the far side it drives a plain register bus made of an address, write data, read data, a write strobe and a read strobe.

A debugger scans in a 40-bit word whose top bit picks write or read, whose next seven bits name the register and whose low 32 bits carry data. Update-DR turns that word into a single bus access. A write completes there. A read fetches the register into a holding buffer, and the next Capture-DR copies that buffer into the data field so the following scan carries the result out. The chain is live only when it is selected and the loaded instruction is INTEST. Under any other instruction, including EXTEST, it leaves the register file alone and the serial path goes through a one-bit bypass.

Top module: `trc_scan_chain`

## Requirements
- R1: When access is enabled, the chain is exactly 40 bits and shifts least-significant bit first: each Shift-DR cycle moves `tdi` into bit 39 and presents bit 0 on `tdo`. A word shifted in with no capture comes out unchanged on the next 40 shifts.
- R2: When access is enabled and Update-DR is seen with bit 39 = 1, `reg_wr` is high for exactly the one cycle after Update-DR. In that cycle `reg_addr` equals bits 38..32 and `reg_wdata` equals bits 31..0.
- R3: When access is enabled and Update-DR is seen with bit 39 = 0, `reg_rd` is high for exactly the one cycle after Update-DR, with `reg_addr` equal to bits 38..32. `reg_wr` stays low.
- R4: `reg_rdata`, sampled during the `reg_rd` cycle, is held in a buffer. An enabled Capture-DR loads that buffer into bits 31..0 and leaves bits 39..32 as they were last shifted.
- R5: Access is enabled only when `chain_sel` is high and `instr_code` equals the INTEST code (parameter, default 4'hC). Under any other code, EXTEST (4'h0) included, no capture, shift or update raises `reg_wr` or `reg_rd`.
- R6: When access is disabled, `tdo` comes from a one-bit bypass stage. Capture-DR clears it to 0 and each Shift-DR cycle loads `tdi` into it, so the scan-out is the scan-in delayed by one bit, with a leading 0.
- R7: After synchronous reset the chain, the read buffer and the bypass bit are all zero, and `reg_wr` and `reg_rd` are low.
- R8: `reg_wr` and `reg_rd` are never high in the same cycle.
- R9: Capture, shift and update while access is disabled leave the 40-bit chain contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the TAP controller |
| rst | input | 1 | Synchronous active-high reset |
| chain_sel | input | 1 | This data register is the one the TAP has selected |
| instr_code | input | IR_W | Instruction currently loaded in the TAP |
| capture_dr | input | 1 | TAP is in Capture-DR this cycle |
| shift_dr | input | 1 | TAP is in Shift-DR this cycle |
| update_dr | input | 1 | TAP is in Update-DR this cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| reg_addr | output | 7 | Register file address |
| reg_wdata | output | 32 | Register file write data |
| reg_rdata | input | 32 | Register file read data, valid in the `reg_rd` cycle |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |

## Verification
The hardest case to reach is a disabled access that happens while the chain already holds a meaningful word. Only then can a leak into the chain (R9) or onto the bus (R5) be told apart from correct behaviour. The stimulus first loads a known word under INTEST. It then runs a full capture, shift and update carrying a write request under EXTEST, and again with the chain deselected. Finally it returns to INTEST and shifts out without a capture, expecting the original word back, no strobe counted, and the bypass pattern seen on `tdo` in between. Read results travel across two scans, and the bench confirms them against its own register-file image.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 32;
    localparam int CHAIN_W = 1 + ADDR_W + DATA_W;

    typedef struct packed {
        logic              is_write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } chain_word_t;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_op_e;

    function automatic bus_op_e op_of(input chain_word_t w);
        return w.is_write ? BUS_WRITE : BUS_READ;
    endfunction

endpackage

// File: rtl/trc_access_gate.sv
module trc_access_gate #(
    parameter int               IR_W      = 4,
    parameter logic [IR_W-1:0]  IR_INTEST = 4'hC
) (
    input  logic            chain_sel,
    input  logic [IR_W-1:0] instr_code,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    output logic            acc_en,
    output logic            chain_cap,
    output logic            chain_shf,
    output logic            chain_upd,
    output logic            byp_cap,
    output logic            byp_shf
);
    always_comb begin
        acc_en    = chain_sel && (instr_code == IR_INTEST);
        chain_cap = acc_en && capture_dr;
        chain_shf = acc_en && shift_dr;
        chain_upd = acc_en && update_dr;
        byp_cap   = !acc_en && capture_dr;
        byp_shf   = !acc_en && shift_dr;
    end
endmodule

// File: rtl/trc_shift_reg.sv
module trc_shift_reg
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic              shf_en,
    input  logic              tdi,
    input  logic [DATA_W-1:0] load_data,
    output chain_word_t       word_o,
    output logic              tdo_o
);
    chain_word_t word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (cap_en) begin
            word_q.data <= load_data;
        end else if (shf_en) begin
            word_q <= chain_word_t'({tdi, word_q[CHAIN_W-1:1]});
        end
    end

    assign word_o = word_q;
    assign tdo_o  = word_q[0];
endmodule

// File: rtl/trc_bypass.sv
module trc_bypass (
    input  logic clk,
    input  logic rst,
    input  logic cap_en,
    input  logic shf_en,
    input  logic tdi,
    output logic bit_o
);
    logic bit_q;

    always_ff @(posedge clk) begin
        if (rst || cap_en) begin
            bit_q <= 1'b0;
        end else if (shf_en) begin
            bit_q <= tdi;
        end
    end

    assign bit_o = bit_q;
endmodule

// File: rtl/trc_bus_seq.sv
module trc_bus_seq
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  chain_word_t       word_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              wr_o,
    output logic              rd_o,
    output logic [DATA_W-1:0] rbuf_o
);
    bus_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rbuf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= BUS_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rbuf_q  <= '0;
        end else begin
            op_q <= BUS_IDLE;
            if (upd_en) begin
                op_q   <= op_of(word_i);
                addr_q <= word_i.addr;
                if (word_i.is_write) begin
                    wdata_q <= word_i.data;
                end
            end
            if (op_q == BUS_READ) begin
                rbuf_q <= rdata_i;
            end
        end
    end

    assign addr_o  = addr_q;
    assign wdata_o = wdata_q;
    assign wr_o    = (op_q == BUS_WRITE);
    assign rd_o    = (op_q == BUS_READ);
    assign rbuf_o  = rbuf_q;
endmodule

// File: rtl/trc_scan_chain.sv
module trc_scan_chain
    import trc_pkg::*;
#(
    parameter int              IR_W      = 4,
    parameter logic [IR_W-1:0] IR_INTEST = 4'hC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chain_sel,
    input  logic [IR_W-1:0]   instr_code,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_wr,
    output logic              reg_rd
);
    logic        acc_en, chain_cap, chain_shf, chain_upd, byp_cap, byp_shf;
    logic        chain_tdo, byp_bit;
    chain_word_t word;
    logic [DATA_W-1:0] rbuf;

    trc_access_gate #(.IR_W(IR_W), .IR_INTEST(IR_INTEST)) u_gate (
        .chain_sel  (chain_sel),
        .instr_code (instr_code),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .acc_en     (acc_en),
        .chain_cap  (chain_cap),
        .chain_shf  (chain_shf),
        .chain_upd  (chain_upd),
        .byp_cap    (byp_cap),
        .byp_shf    (byp_shf)
    );

    trc_shift_reg u_chain (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (chain_cap),
        .shf_en    (chain_shf),
        .tdi       (tdi),
        .load_data (rbuf),
        .word_o    (word),
        .tdo_o     (chain_tdo)
    );

    trc_bypass u_byp (
        .clk    (clk),
        .rst    (rst),
        .cap_en (byp_cap),
        .shf_en (byp_shf),
        .tdi    (tdi),
        .bit_o  (byp_bit)
    );

    trc_bus_seq u_bus (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (chain_upd),
        .word_i  (word),
        .rdata_i (reg_rdata),
        .addr_o  (reg_addr),
        .wdata_o (reg_wdata),
        .wr_o    (reg_wr),
        .rd_o    (reg_rd),
        .rbuf_o  (rbuf)
    );

    assign tdo = acc_en ? chain_tdo : byp_bit;
endmodule

// File: rtl/trc_scan_chain_chk.sv
module trc_scan_chain_chk #(
    parameter int              IR_W      = 4,
    parameter logic [IR_W-1:0] IR_INTEST = 4'hC
) (
    input logic            clk,
    input logic            rst,
    input logic            chain_sel,
    input logic [IR_W-1:0] instr_code,
    input logic            capture_dr,
    input logic            shift_dr,
    input logic            update_dr,
    input logic            tdi,
    input logic            tdo,
    input logic            reg_wr,
    input logic            reg_rd
);
    logic acc;
    assign acc = chain_sel && (instr_code == IR_INTEST);

    // R2: a write strobe follows an enabled Update-DR
    p_wr_cause_r2: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> $past(acc && update_dr));

    // R3: a read strobe follows an enabled Update-DR
    p_rd_cause_r3: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> $past(acc && update_dr));

    // R5: no bus strobe after a cycle with access disabled
    p_quiet_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(acc) |-> (!reg_wr && !reg_rd));

    // R6: bypass delays tdi by one shift cycle
    p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(shift_dr) && !$past(capture_dr) && !$past(acc) && !acc)
            |-> (tdo == $past(tdi)));

    // R7: strobes low in the first cycle out of reset
    p_reset_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!reg_wr && !reg_rd));

    // R8: strobes mutually exclusive
    p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));
endmodule

bind trc_scan_chain trc_scan_chain_chk #(.IR_W(IR_W), .IR_INTEST(IR_INTEST)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .chain_sel  (chain_sel),
    .instr_code (instr_code),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .tdi        (tdi),
    .tdo        (tdo),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd)
);

// File: tb/trc_scan_chain_tb_top.sv
module trc_scan_chain_tb_top;
    localparam int        CLK_PERIOD = 10;
    localparam logic [3:0] IR_IN  = 4'hC;
    localparam logic [3:0] IR_EX  = 4'h0;
    localparam int        NVEC   = 7;

    // bit 39 = 1 write / 0 read, 38..32 address, 31..0 data
    localparam logic [39:0] VECS [NVEC] = '{
        {1'b1, 7'd5,   32'hDEAD_BEEF},
        {1'b1, 7'd127, 32'h0000_0001},
        {1'b0, 7'd5,   32'h1234_5678},
        {1'b1, 7'd0,   32'hA5A5_5A5A},
        {1'b0, 7'd127, 32'hFFFF_FFFF},
        {1'b0, 7'd0,   32'h0000_0000},
        {1'b0, 7'd3,   32'h0BAD_F00D}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chain_sel = 1'b1;
    logic [3:0]  instr_code = IR_IN;
    logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic        tdo, reg_wr, reg_rd;
    logic [6:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    logic [31:0] bmem    [128];
    logic [31:0] exp_mem [128];
    int wr_cnt = 0, rd_cnt = 0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trc_scan_chain dut_i (
        .clk(clk), .rst(rst), .chain_sel(chain_sel), .instr_code(instr_code),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_rd(reg_rd)
    );

    assign reg_rdata = bmem[reg_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) bmem[i] <= 32'h1000_0000 + i;
        end else begin
            if (reg_wr) begin
                bmem[reg_addr] <= reg_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (reg_rd) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_dr(input logic [39:0] w, input bit cap, input bit upd,
                         output logic [39:0] o);
        if (cap) begin
            @(negedge clk) capture_dr = 1'b1;
        end
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            capture_dr = 1'b0;
            shift_dr   = 1'b1;
            o[i]       = tdo;
            tdi        = w[i];
        end
        @(negedge clk);
        shift_dr  = 1'b0;
        update_dr = upd;
        if (upd) begin
            @(negedge clk) update_dr = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [39:0] o;
        logic [39:0] keep;
        int w0, r0;
        for (int i = 0; i < 128; i++) exp_mem[i] = 32'h1000_0000 + i;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R7 reset state
        chk("R7 wr", {63'd0, reg_wr}, 64'd0);
        chk("R7 rd", {63'd0, reg_rd}, 64'd0);
        chk("R7 tdo", {63'd0, tdo}, 64'd0);
        do_dr(40'hC3_1122_3344, 1'b0, 1'b0, o);
        chk("R7 chain zero", {24'd0, o}, 64'd0);

        // R1 LSB-first pass-through
        do_dr(40'h5A_0F0F_1234, 1'b0, 1'b0, o);
        chk("R1 previous word", {24'd0, o}, {24'd0, 40'hC3_1122_3344});
        do_dr(40'h00_0000_0000, 1'b0, 1'b0, o);
        chk("R1 shifted word", {24'd0, o}, {24'd0, 40'h5A_0F0F_1234});

        // vector table: R2 writes, R3/R4 reads
        for (int v = 0; v < NVEC; v++) begin
            w0 = wr_cnt;
            r0 = rd_cnt;
            do_dr(VECS[v], 1'b0, 1'b1, o);
            if (VECS[v][39]) begin
                chk("R2 wr strobe", {63'd0, reg_wr}, 64'd1);
                chk("R2 addr", {57'd0, reg_addr}, {57'd0, VECS[v][38:32]});
                chk("R2 wdata", {32'd0, reg_wdata}, {32'd0, VECS[v][31:0]});
                chk("R8 no rd during wr", {63'd0, reg_rd}, 64'd0);
                exp_mem[VECS[v][38:32]] = VECS[v][31:0];
                @(negedge clk);
                chk("R2 single pulse", 64'(wr_cnt - w0), 64'd1);
                chk("R3 no rd on write", 64'(rd_cnt - r0), 64'd0);
            end else begin
                chk("R3 rd strobe", {63'd0, reg_rd}, 64'd1);
                chk("R3 addr", {57'd0, reg_addr}, {57'd0, VECS[v][38:32]});
                chk("R3 no wr", {63'd0, reg_wr}, 64'd0);
                @(negedge clk);
                chk("R3 single pulse", 64'(rd_cnt - r0), 64'd1);
                do_dr(40'h0, 1'b1, 1'b0, o);
                chk("R4 data", {32'd0, o[31:0]}, {32'd0, exp_mem[VECS[v][38:32]]});
                chk("R4 header kept", {56'd0, o[39:32]}, {56'd0, VECS[v][39:32]});
            end
        end

        // R5/R6/R9 EXTEST: bypass, no strobes, chain untouched
        keep = 40'h3C_9876_ABCD;
        do_dr(keep, 1'b0, 1'b0, o);
        instr_code = IR_EX;
        w0 = wr_cnt;
        r0 = rd_cnt;
        do_dr(40'hFF_CAFE_F00D, 1'b1, 1'b1, o);
        chk("R6 bypass extest", {24'd0, o}, {24'd0, 39'h7F_CAFE_F00D & 39'h7F_FFFF_FFFF, 1'b0});
        @(negedge clk);
        chk("R5 extest no wr", 64'(wr_cnt - w0), 64'd0);
        chk("R5 extest no rd", 64'(rd_cnt - r0), 64'd0);
        instr_code = IR_IN;
        do_dr(keep, 1'b0, 1'b0, o);
        chk("R9 chain kept extest", {24'd0, o}, {24'd0, keep});

        // R5/R6/R9 deselected under INTEST
        chain_sel = 1'b0;
        w0 = wr_cnt;
        r0 = rd_cnt;
        do_dr(40'h7E_1357_2468, 1'b1, 1'b1, o);
        chk("R6 bypass deselected", {24'd0, o}, {24'd0, 39'h7E_1357_2468, 1'b0});
        @(negedge clk);
        chk("R5 deselected no strobe", 64'((wr_cnt - w0) + (rd_cnt - r0)), 64'd0);
        chain_sel = 1'b1;
        do_dr(40'h0, 1'b0, 1'b0, o);
        chk("R9 chain kept deselected", {24'd0, o}, {24'd0, keep});
        chk("R5 memory untouched", {32'd0, bmem[7'd126]}, {32'd0, exp_mem[126]});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule